// File: doc/BRIEF.md
# Fetch-Gated SPI Access Controller

This block decides whether software may use an SPI master. It watches the CPU instruction-fetch bus. Access is granted only after the CPU fetches an instruction from one entry address. Software programs that entry address and normally places it in ROM. Access is withdrawn as soon as the CPU fetches an instruction from the RAM region. The effect is that only code entered through the trusted entry point can drive the SPI peripheral, and code running from RAM cannot.

A 32-bit register port holds the entry-address register and fronts the three SPI registers: enable, transfer/ready and data. The SPI shift engine itself is a stub. A transfer keeps the peripheral busy for a fixed number of cycles. It then returns the inverse of the transmit byte as the received byte, which works as a loopback.

The register port is read combinationally. `regRdata` is valid in the same cycle that `regCs` is high and `regWe` is low, and it is 0 otherwise. Register writes take effect on the clock edge.

Top module: `spi_fetch_gate`

## Requirements
- R1: After reset, access is denied. The entry-address register (offset 0x83) reads 0x00000000, and the transfer/ready register (offset 0x81) reads 0.
- R2: The entry-address register at offset 0x83 is writable and reads back unchanged whether access is granted or denied.
- R3: A cycle with `cpuValid`=1, `cpuInstr`=1 and `cpuAddr` equal to the entry address grants access from the next clock edge on. While granted and idle, the transfer/ready register reads 1 in bit 0.
- R4: An instruction fetch from the RAM region, meaning `cpuAddr[31:28]`==4'h4, denies access from the next clock edge on.
- R5: Access state does not change in these cases:
  - instruction fetches from any other address;
  - cycles with `cpuInstr`=0;
  - cycles with `cpuValid`=0.
- R6: After the entry address is reprogrammed, a fetch from the old address no longer grants access. A fetch from the new address does grant it.
- R7: While access is denied, reads of offsets 0x80 (enable, bit 0), 0x81 (ready, bit 0) and 0x82 (received byte, bits 7:0) return 0.
- R8: While access is denied, writes to offsets 0x80, 0x81 and 0x82 have no effect on the enable bit, on the transmit byte or on the transfer engine.
- R9: While access is granted and enable is 1, any write to offset 0x81 while ready starts a transfer. Ready reads 0 for XFER_CYCLES cycles. After that, ready reads 1 and offset 0x82 reads the bitwise inverse of the transmit byte.
- R10: If the entry address itself lies in the RAM region, a fetch from it grants access. The match takes priority over the RAM-region decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 32 | CPU bus address |
| cpuInstr | input | 1 | Bus cycle is an instruction fetch |
| cpuValid | input | 1 | Bus cycle is valid |
| regCs | input | 1 | Register port select |
| regWe | input | 1 | Register write enable |
| regAddr | input | 8 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |

## Verification
A wrong access state appears at the ports as soon as the transfer/ready register is read, one edge after the fetch that should have changed it. A granted state reads 1 and a denied state reads 0. A dropped or misdirected write to the entry address is seen immediately on readback. A gate that leaks writes while denied stays hidden until access is granted again. It then shows as an enable bit that is already set, a peripheral that is already busy, or a received byte that does not match the transmit byte written while granted.

// File: rtl/spi_gate_pkg.sv
package spi_gate_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_EN   = 8'h80;
  localparam logic [REG_AW-1:0] OFS_XFER = 8'h81;
  localparam logic [REG_AW-1:0] OFS_DATA = 8'h82;
  localparam logic [REG_AW-1:0] OFS_CMD  = 8'h83;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CMD,
    RD_EN,
    RD_XFER,
    RD_DATA
  } rdSel_t;

  typedef struct packed {
    logic   wrCmd;
    logic   wrEn;
    logic   wrXfer;
    logic   wrData;
    rdSel_t rdSel;
    logic   granted;
  } gateStrb_t;
endpackage

// File: rtl/spi_gate_ctrl.sv
module spi_gate_ctrl
  import spi_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [3:0] RAM_NIBBLE = 4'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuInstr,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              regCs,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output gateStrb_t         strb
);
  logic accessQ;
  logic fetch;
  logic entryHit;
  logic ramFetch;

  assign fetch    = cpuValid && cpuInstr;
  assign entryHit = fetch && (cpuAddr == cmdAddr);
  assign ramFetch = fetch && (cpuAddr[ADDR_W-1 -: 4] == RAM_NIBBLE);

  always_ff @(posedge clk) begin
    if (!rstN)         accessQ <= 1'b0;
    else if (entryHit) accessQ <= 1'b1;
    else if (ramFetch) accessQ <= 1'b0;
  end

  logic wrCyc;
  logic rdCyc;
  assign wrCyc = regCs && regWe;
  assign rdCyc = regCs && !regWe;

  always_comb begin
    strb         = '0;
    strb.granted = accessQ;
    strb.rdSel   = RD_NONE;
    strb.wrCmd   = wrCyc && (regAddr == OFS_CMD);
    strb.wrEn    = wrCyc && accessQ && (regAddr == OFS_EN);
    strb.wrXfer  = wrCyc && accessQ && (regAddr == OFS_XFER);
    strb.wrData  = wrCyc && accessQ && (regAddr == OFS_DATA);
    if (rdCyc) begin
      case (regAddr)
        OFS_CMD:  strb.rdSel = RD_CMD;
        OFS_EN:   strb.rdSel = accessQ ? RD_EN   : RD_NONE;
        OFS_XFER: strb.rdSel = accessQ ? RD_XFER : RD_NONE;
        OFS_DATA: strb.rdSel = accessQ ? RD_DATA : RD_NONE;
        default:  strb.rdSel = RD_NONE;
      endcase
    end
  end

  // R3 / R10: a fetch from the entry address grants on the next edge
  a_r3_entry_grants: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuInstr && cpuAddr == cmdAddr) |=> accessQ);

  // R4: a RAM fetch that misses the entry address revokes access
  a_r4_ram_revokes: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuInstr && cpuAddr != cmdAddr &&
     cpuAddr[ADDR_W-1 -: 4] == RAM_NIBBLE) |=> !accessQ);

  // R5: cycles that are not fetches never move the access state
  a_r5_nonfetch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuValid && cpuInstr) |=> $stable(accessQ));
endmodule

// File: rtl/spi_gate_dpath.sv
module spi_gate_dpath
  import spi_gate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SPI_W       = 8,
  parameter int XFER_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] regRdata
);
  localparam int CNT_W = $clog2(XFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYCLES);

  logic             spiEnable;
  logic [SPI_W-1:0] txByte;
  logic [SPI_W-1:0] rxByte;
  logic [CNT_W-1:0] busyCnt;
  logic             spiReady;
  logic             startXfer;

  assign spiReady  = (busyCnt == '0);
  assign startXfer = strb.wrXfer && spiEnable && spiReady;

  always_ff @(posedge clk) begin
    if (!rstN) cmdAddr <= '0;
    else if (strb.wrCmd) cmdAddr <= regWdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiEnable <= 1'b0;
      txByte    <= '0;
    end else begin
      if (strb.wrEn)   spiEnable <= regWdata[0];
      if (strb.wrData) txByte    <= regWdata[SPI_W-1:0];
    end
  end

  // Shift-engine stub: fixed busy time, inverted loopback.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      rxByte  <= '0;
    end else if (startXfer) begin
      busyCnt <= CNT_LOAD;
    end else if (!spiReady) begin
      busyCnt <= busyCnt - 1'b1;
      if (busyCnt == CNT_W'(1)) rxByte <= ~txByte;
    end
  end

  always_comb begin
    regRdata = '0;
    case (strb.rdSel)
      RD_CMD:  regRdata[ADDR_W-1:0] = cmdAddr;
      RD_EN:   regRdata[0]          = spiEnable;
      RD_XFER: regRdata[0]          = spiReady;
      RD_DATA: regRdata[SPI_W-1:0]  = rxByte;
      default: regRdata             = '0;
    endcase
  end

  // R8: with access denied the enable bit and transmit byte cannot move
  a_r8_denied_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !strb.granted |=> ($stable(spiEnable) && $stable(txByte)));

  // R8: no transfer can start while denied
  a_r8_denied_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.granted && spiReady) |=> spiReady);

  // R9: busy counter never exceeds its load value
  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_LOAD);
endmodule

// File: rtl/spi_fetch_gate.sv
module spi_fetch_gate
  import spi_gate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SPI_W       = 8,
  parameter int XFER_CYCLES = 8,
  parameter logic [3:0] RAM_NIBBLE = 4'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuInstr,
  input  logic              cpuValid,
  input  logic              regCs,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata
);
  gateStrb_t         strb;
  logic [ADDR_W-1:0] cmdAddr;

  spi_gate_ctrl #(
    .ADDR_W(ADDR_W), .RAM_NIBBLE(RAM_NIBBLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuInstr(cpuInstr),
    .cpuValid(cpuValid), .cmdAddr(cmdAddr), .regCs(regCs), .regWe(regWe),
    .regAddr(regAddr), .strb(strb)
  );

  spi_gate_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPI_W(SPI_W), .XFER_CYCLES(XFER_CYCLES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .cmdAddr(cmdAddr), .regRdata(regRdata)
  );

  // R7: SPI register reads return zero while access is denied
  a_r7_denied_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.granted && regCs && !regWe &&
     (regAddr == OFS_EN || regAddr == OFS_XFER || regAddr == OFS_DATA))
    |-> (regRdata == '0));

  // R2: the entry-address register reads back what was last written
  a_r2_cmd_readback: assert property (@(posedge clk) disable iff (!rstN)
    (regCs && regWe && regAddr == OFS_CMD) |=> (cmdAddr == $past(regWdata[ADDR_W-1:0])));
endmodule

// File: tb/sim_spi_fetch_gate.sv
module sim_spi_fetch_gate;
  localparam int CLK_PERIOD = 10;
  localparam int XFER_CYC   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        cpuInstr = 1'b0;
  logic        cpuValid = 1'b0;
  logic        regCs = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        expAccess = 1'b0;
  logic [31:0] expCmd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fetch_gate #(.XFER_CYCLES(XFER_CYC)) u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuInstr(cpuInstr),
    .cpuValid(cpuValid), .regCs(regCs), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic nextAccess(logic cur, logic v, logic i,
                                      logic [31:0] a, logic [31:0] cmd);
    if (v && i && a == cmd)        return 1'b1;
    if (v && i && a[31:28] == 4'h4) return 1'b0;
    return cur;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08x expected 0x%08x", req, got, exp);
    end
  endtask

  task automatic fetch(logic [31:0] a, logic v, logic i);
    @(negedge clk);
    cpuAddr = a; cpuValid = v; cpuInstr = i;
    expAccess = nextAccess(expAccess, v, i, a, expCmd);
    @(negedge clk);
    cpuValid = 1'b0; cpuInstr = 1'b0;
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regCs = 1'b1; regWe = 1'b1; regAddr = a; regWdata = d;
    if (a == 8'h83) expCmd = d;
    @(negedge clk);
    regCs = 1'b0; regWe = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regCs = 1'b1; regWe = 1'b0; regAddr = a;
    #1 d = regRdata;
    #1 regCs = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(8'h81, d); check("R1 xfer after reset", d, 0);
    regRead(8'h83, d); check("R1 cmd after reset", d, 0);

    // R2 and R7/R8 while denied
    regWrite(8'h83, 32'h0000dead);
    regRead(8'h83, d); check("R2 cmd readback denied", d, 32'h0000dead);
    regWrite(8'h80, 32'h1);
    regRead(8'h80, d); check("R7 enable reads zero denied", d, 0);

    // R5 non-fetch cycles and other fetches do not grant
    fetch(32'h0000dead, 1'b1, 1'b0);
    regRead(8'h81, d); check("R5 data access no grant", d, 0);
    fetch(32'h0000dead, 1'b0, 1'b1);
    regRead(8'h81, d); check("R5 invalid no grant", d, 0);

    // R3 grant
    fetch(32'h0000dead, 1'b1, 1'b1);
    regRead(8'h81, d); check("R3 grant after entry fetch", d, 1);
    regRead(8'h80, d); check("R8 enable write ignored while denied", d, 0);
    fetch(32'h00001234, 1'b1, 1'b1);
    regRead(8'h81, d); check("R5 other fetch keeps grant", d, 1);
    fetch(32'h40000000, 1'b1, 1'b0);
    regRead(8'h81, d); check("R5 RAM data access keeps grant", d, 1);

    // R9 transfer
    regWrite(8'h82, 32'ha7);
    regWrite(8'h80, 32'h1);
    regWrite(8'h81, 32'h1);
    regRead(8'h81, d); check("R9 busy after start", d, 0);
    repeat (XFER_CYC + 2) @(negedge clk);
    regRead(8'h81, d); check("R9 ready after transfer", d, 1);
    regRead(8'h82, d); check("R9 loopback byte", d, 32'h58);

    // R4 revoke, R7 reads, R8 writes
    fetch(32'h4000dead, 1'b1, 1'b1);
    regRead(8'h81, d); check("R4 RAM fetch revokes", d, 0);
    regRead(8'h82, d); check("R7 data reads zero denied", d, 0);
    regWrite(8'h82, 32'h11);
    regWrite(8'h81, 32'h1);
    regWrite(8'h80, 32'h0);
    fetch(32'h0000dead, 1'b1, 1'b1);
    regRead(8'h81, d); check("R8 xfer write ignored while denied", d, 1);
    regRead(8'h80, d); check("R8 enable clear ignored while denied", d, 1);
    regWrite(8'h81, 32'h1);
    repeat (XFER_CYC + 2) @(negedge clk);
    regRead(8'h82, d); check("R8 data write ignored while denied", d, 32'h58);

    // R6 reprogramming
    fetch(32'h40000004, 1'b1, 1'b1);
    regWrite(8'h83, 32'h0000cafe);
    regRead(8'h83, d); check("R2 cmd readback", d, 32'h0000cafe);
    fetch(32'h0000dead, 1'b1, 1'b1);
    regRead(8'h81, d); check("R6 old address no grant", d, 0);
    fetch(32'h0000cafe, 1'b1, 1'b1);
    regRead(8'h81, d); check("R6 new address grants", d, 1);

    // R10 entry address in RAM region
    regWrite(8'h83, 32'h40000100);
    fetch(32'h40000200, 1'b1, 1'b1);
    regRead(8'h81, d); check("R4 RAM fetch revokes again", d, 0);
    fetch(32'h40000100, 1'b1, 1'b1);
    regRead(8'h81, d); check("R10 entry match wins over RAM", d, 1);

    // Random mix against the bench model (R3 R4 R5)
    regWrite(8'h83, 32'h00000800);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int sel;
      sel = $urandom % 3;
      if (sel == 0)      a = expCmd;
      else if (sel == 1) a = {4'h4, 28'($urandom)};
      else               a = {4'h1, 28'($urandom)};
      fetch(a, 1'($urandom), 1'($urandom));
      regRead(8'h81, d);
      check("R5 random fetch model", d, {31'b0, expAccess});
    end

    done = 1'b1;
    summary();
  end
endmodule